// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Logic

This block holds the write-only FIFO control register of one UART channel and the interrupt logic on the FIFO side of that channel. A host write to the control register turns both FIFOs on or off. The same write chooses the receive and transmit trigger levels, stores a legacy DMA-mode bit and can fire one-cycle reset strobes that empty either FIFO. The rule for programming is strict: only a write that also has the enable bit set changes any field or fires any strobe. A write with the enable bit clear turns the FIFOs off and changes nothing else.

Each FIFO is modelled as a fill-level counter driven by push and pop strobes. The receive interrupt follows the receive level against its trigger. The transmit interrupt is driven by a small state machine that remembers whether the last refill took the level above the transmit trigger:

- **TX_IDLE.** No refill above the trigger has been seen. A pop that empties the FIFO moves it to TX_PEND. A level above the trigger moves it to TX_ARMED.
- **TX_ARMED.** A refill went above the trigger. A level below the trigger moves it to TX_PEND.
- **TX_PEND.** The interrupt is raised. A refill above the trigger moves it to TX_ARMED. A status read that reports the transmit source moves it to TX_IDLE.

A transmit FIFO reset forces TX_IDLE from any state. A combinational status byte reports the FIFO enable state, the pending source of highest priority and a "none pending" flag.

Top module: `uart_fifo_ctl`

## Requirements
- R1: A write with wr_data[0]=1 turns the FIFOs on, so that stat_byte[7:6] reads 11. A write with wr_data[0]=0 turns them off, so that stat_byte[7:6] reads 00, and leaves the trigger selections and dma_mode unchanged.
- R2: A write with wr_data[0]=1 and wr_data[1]=1 empties the RX level counter. The empty count is visible by the second rising edge after the write, and the TX level is untouched. wr_data[2] does the same for the TX counter and also returns the TX interrupt machine to TX_IDLE. Each strobe lasts one cycle, so later pushes count normally.
- R3: When wr_data[0]=0, the reset bits wr_data[1] and wr_data[2] have no effect.
- R4: wr_data[7:6] selects the RX trigger and wr_data[5:4] selects the TX trigger. Codes 00, 01, 10 and 11 give 1, DEPTH/4, DEPTH/2 and DEPTH-2 characters, which is 1, 4, 8 and 14 at the default DEPTH of 16.
- R5: rx_irq is 1 exactly while rx_lvl is at or above the RX trigger. A status read does not clear it.
- R6: Once the TX level has been above the TX trigger, tx_irq rises two clock edges after the pop that takes the level below the trigger. A level equal to the trigger raises nothing.
- R7: If no refill took the TX level above the trigger, tx_irq rises two clock edges after a pop that empties the TX FIFO.
- R8: While tx_irq is set and rx_irq is clear, a status read (rd_stat=1) clears tx_irq at the next edge. A refill above the TX trigger also clears tx_irq. A status read while rx_irq is set leaves tx_irq set.
- R9: stat_byte[5:1] reads 00010 when rx_irq is set, 00001 when only tx_irq is set, and 00000 otherwise. stat_byte[0] is 0 when either interrupt is pending and 1 when neither is.
- R10: wr_data[3] is stored on dma_mode by an enabled write and has no effect on any other output.
- R11: A push increments the level and a pop decrements it. A push at DEPTH and a pop at 0 are ignored. A push and a pop in the same cycle on a non-empty FIFO leave the level unchanged. On an empty FIFO the push counts and the pop is ignored.
- R12: The synchronous active-high reset gives stat_byte=0x01, both levels 0, both interrupts 0 and dma_mode 0. It also clears all trigger codes to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_stat | input | 1 | Status byte read strobe |
| rx_push | input | 1 | RX FIFO push strobe |
| rx_pop | input | 1 | RX FIFO pop strobe |
| tx_push | input | 1 | TX FIFO push strobe |
| tx_pop | input | 1 | TX FIFO pop strobe |
| stat_byte | output | 8 | Interrupt status byte |
| rx_irq | output | 1 | Receive trigger interrupt |
| tx_irq | output | 1 | Transmit trigger interrupt |
| rx_lvl | output | LW | RX fill level |
| tx_lvl | output | LW | TX fill level |
| dma_mode | output | 1 | Stored legacy DMA-mode bit |

## Verification
The assertions check on every cycle the following local rules:
- the counter bounds and the single-step movement of each level;
- that a reset strobe empties its counter;
- that a disabling write keeps the trigger codes;
- that a strobe fires only after an enabled write;
- that a status read clears a pending transmit interrupt;
- that a level above the trigger silences tx_irq;
- that a read never drops rx_irq.

Other behaviour depends on history, and only the bench's scenarios show it. This covers the split between the armed path and the empty path of the transmit interrupt, and source priority when both interrupts are pending. It also covers proof through the interrupt outputs that a disabling write kept the trigger selection.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_PEND  = 2'd2
    } tx_state_t;

    localparam logic [4:0] SRC_RX   = 5'b00010;
    localparam logic [4:0] SRC_TX   = 5'b00001;
    localparam logic [4:0] SRC_NONE = 5'b00000;

    function automatic int trig_level(input logic [1:0] code, input int depth);
        int t;
        unique case (code)
            2'b00:   t = 1;
            2'b01:   t = depth / 4;
            2'b10:   t = depth / 2;
            default: t = depth - 2;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/uart_fcr_reg.sv
module uart_fcr_reg (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fifo_on,
    output logic [1:0] rx_code,
    output logic [1:0] tx_code,
    output logic       dma_bit,
    output logic       rx_clr,
    output logic       tx_clr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_on <= 1'b0;
            rx_code <= 2'b00;
            tx_code <= 2'b00;
            dma_bit <= 1'b0;
            rx_clr  <= 1'b0;
            tx_clr  <= 1'b0;
        end else begin
            rx_clr <= 1'b0;
            tx_clr <= 1'b0;
            if (wr_en) begin
                if (wr_data[0]) begin
                    fifo_on <= 1'b1;
                    rx_code <= wr_data[7:6];
                    tx_code <= wr_data[5:4];
                    dma_bit <= wr_data[3];
                    rx_clr  <= wr_data[1];
                    tx_clr  <= wr_data[2];
                end else begin
                    fifo_on <= 1'b0;
                end
            end
        end
    end

    AST_OFF_KEEPS_TRIG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[0]) |=> (rx_code == $past(rx_code) && tx_code == $past(tx_code)
                                     && dma_bit == $past(dma_bit))); // R1

    AST_RXCLR_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
        rx_clr |-> $past(wr_en && wr_data[0] && wr_data[1])); // R3

    AST_TXCLR_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
        tx_clr |-> $past(wr_en && wr_data[0] && wr_data[2])); // R3

endmodule

// File: rtl/uart_fifo_level.sv
module uart_fifo_level #(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    output logic [LW-1:0] lvl,
    output logic          drained
);

    localparam logic [LW-1:0] FULL = LW'(DEPTH);
    localparam logic [LW-1:0] ONE  = LW'(1);

    logic pop_ok;
    logic push_ok;

    always_comb begin
        pop_ok  = pop && (lvl != '0);
        push_ok = push && ((lvl != FULL) || pop_ok);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl     <= '0;
            drained <= 1'b0;
        end else begin
            lvl     <= lvl + (push_ok ? ONE : '0) - (pop_ok ? ONE : '0);
            drained <= pop_ok && !push_ok && (lvl == ONE);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        lvl <= FULL); // R11

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (lvl == $past(lvl) || lvl == $past(lvl) + ONE || lvl + ONE == $past(lvl))); // R11

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lvl == '0)); // R2

endmodule

// File: rtl/uart_tx_irq_fsm.sv
module uart_tx_irq_fsm
    import uart_fifo_pkg::*;
#(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [LW-1:0] lvl,
    input  logic [LW-1:0] trig,
    input  logic          drained,
    input  logic          rd_ack,
    output logic          irq
);

    tx_state_t state;
    tx_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = TX_IDLE;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (lvl > trig)   nxt = TX_ARMED;
                    else if (drained) nxt = TX_PEND;
                end
                TX_ARMED: begin
                    if (lvl < trig)   nxt = TX_PEND;
                end
                TX_PEND: begin
                    if (lvl > trig)   nxt = TX_ARMED;
                    else if (rd_ack)  nxt = TX_IDLE;
                end
                default: nxt = TX_IDLE;
            endcase
        end
    end

    always_comb begin
        irq = (state == TX_PEND);
    end

    AST_TX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (irq && rd_ack && !clr && lvl <= trig) |=> !irq); // R8

    AST_TX_ABOVE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (lvl > trig) |=> !irq); // R8

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_stat,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_pop,
    output logic [7:0]    stat_byte,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic [LW-1:0] rx_lvl,
    output logic [LW-1:0] tx_lvl,
    output logic          dma_mode
);

    logic          fifo_on;
    logic [1:0]    rx_code;
    logic [1:0]    tx_code;
    logic          rx_clr;
    logic          tx_clr;
    logic          rx_drained;
    logic          tx_drained;
    logic [LW-1:0] rx_trig;
    logic [LW-1:0] tx_trig;
    logic          rd_ack;
    logic [4:0]    src;

    uart_fcr_reg u_fcr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .fifo_on (fifo_on),
        .rx_code (rx_code),
        .tx_code (tx_code),
        .dma_bit (dma_mode),
        .rx_clr  (rx_clr),
        .tx_clr  (tx_clr)
    );

    uart_fifo_level #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk     (clk),
        .rst     (rst),
        .clr     (rx_clr),
        .push    (rx_push),
        .pop     (rx_pop),
        .lvl     (rx_lvl),
        .drained (rx_drained)
    );

    uart_fifo_level #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk     (clk),
        .rst     (rst),
        .clr     (tx_clr),
        .push    (tx_push),
        .pop     (tx_pop),
        .lvl     (tx_lvl),
        .drained (tx_drained)
    );

    always_comb begin
        rx_trig = LW'(trig_level(rx_code, DEPTH));
        tx_trig = LW'(trig_level(tx_code, DEPTH));
        rx_irq  = (rx_lvl >= rx_trig);
        rd_ack  = rd_stat && !rx_irq;
    end

    uart_tx_irq_fsm #(.LW(LW)) u_tx_fsm (
        .clk     (clk),
        .rst     (rst),
        .clr     (tx_clr),
        .lvl     (tx_lvl),
        .trig    (tx_trig),
        .drained (tx_drained),
        .rd_ack  (rd_ack),
        .irq     (tx_irq)
    );

    always_comb begin
        if (rx_irq)      src = SRC_RX;
        else if (tx_irq) src = SRC_TX;
        else             src = SRC_NONE;
        stat_byte = {fifo_on, fifo_on, src, !(rx_irq || tx_irq)};
    end

    AST_RX_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && rd_stat && !rx_pop && !wr_en && !rx_clr) |=> rx_irq); // R5

    AST_RX_UNUSED_DRAIN: assert property (@(posedge clk) disable iff (rst)
        rx_drained |-> (rx_lvl == '0)); // R11

endmodule

// File: tb/uart_fifo_ctl_bench.sv
module uart_fifo_ctl_bench;

    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          rd_stat = 1'b0;
    logic          rx_push = 1'b0;
    logic          rx_pop = 1'b0;
    logic          tx_push = 1'b0;
    logic          tx_pop = 1'b0;
    logic [7:0]    stat_byte;
    logic          rx_irq;
    logic          tx_irq;
    logic [LW-1:0] rx_lvl;
    logic [LW-1:0] tx_lvl;
    logic          dma_mode;

    int n_chk = 0;
    int n_bad = 0;
    int mrx = 0;
    int mtx = 0;
    int rx_t = 1;

    always #4 clk = ~clk;

    uart_fifo_ctl #(.DEPTH(DEPTH)) u_uart_fifo_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_stat(rd_stat),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .stat_byte(stat_byte), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .rx_lvl(rx_lvl), .tx_lvl(tx_lvl), .dma_mode(dma_mode)
    );

    function automatic int trig_of(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic int exp_stat(input int on, input int rxp, input int txp);
        int s;
        s = on ? 8'hC0 : 8'h00;
        if (rxp != 0)      s = s | 8'h04;
        else if (txp != 0) s = s | 8'h02;
        else               s = s | 8'h01;
        return s;
    endfunction

    function automatic int next_lvl(input int l, input int pu, input int po);
        int pok;
        int uok;
        pok = (po != 0 && l != 0) ? 1 : 0;
        uok = (pu != 0 && (l != DEPTH || pok != 0)) ? 1 : 0;
        return l + uok - pok;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int rp, input int ro, input int tp, input int to);
        rx_push = rp[0]; rx_pop = ro[0]; tx_push = tp[0]; tx_pop = to[0];
        @(posedge clk);
        mrx = next_lvl(mrx, rp, ro);
        mtx = next_lvl(mtx, tp, to);
        @(negedge clk);
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        idle(2);
        if (d[0]) begin
            if (d[1]) mrx = 0;
            if (d[2]) mtx = 0;
            rx_t = trig_of(int'(d[7:6]));
        end
    endtask

    task automatic rd();
        rd_stat = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stat = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        chk("R12 reset stat", int'(stat_byte), 8'h01);
        chk("R12 reset rx_lvl", int'(rx_lvl), 0);
        chk("R12 reset tx_lvl", int'(tx_lvl), 0);
        chk("R12 reset irqs", int'({rx_irq, tx_irq}), 0);
        chk("R12 reset dma", int'(dma_mode), 0);
        rst = 1'b0;
        @(negedge clk);

        wr(8'h01);
        chk("R1 enabled stat", int'(stat_byte), exp_stat(1, 0, 0));

        for (int i = 0; i < 17; i++) step(1, 0, 0, 0);
        chk("R11 full saturates", int'(rx_lvl), 16);
        step(1, 1, 0, 0);
        chk("R11 push+pop at full", int'(rx_lvl), 16);
        for (int i = 0; i < 17; i++) step(0, 1, 0, 0);
        chk("R11 empty floor", int'(rx_lvl), 0);
        chk("R4 code00 rx irq at 0", int'(rx_irq), 0);
        step(1, 1, 0, 0);
        chk("R11 push+pop at empty", int'(rx_lvl), 1);
        chk("R4 code00 rx irq at 1", int'(rx_irq), 1);
        step(0, 1, 0, 0);

        wr(8'h81);
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0);
        chk("R4 rx trig8 at 7", int'(rx_irq), 0);
        step(1, 0, 0, 0);
        chk("R5 rx trig8 at 8", int'(rx_irq), 1);
        chk("R9 rx source stat", int'(stat_byte), exp_stat(1, 1, 0));
        rd();
        chk("R5 read keeps rx irq", int'(rx_irq), 1);

        wr(8'h08);
        chk("R1 disabled stat", int'(stat_byte), exp_stat(0, 1, 0));
        chk("R1 dma kept on disable", int'(dma_mode), 0);
        step(0, 1, 0, 0);
        chk("R1 trig kept (lvl7 no irq)", int'(rx_irq), 0);

        wr(8'h02);
        chk("R3 rx reset ignored", int'(rx_lvl), 7);
        chk("R3 still off", int'(stat_byte), exp_stat(0, 0, 0));

        step(0, 0, 1, 0); step(0, 0, 1, 0);
        wr(8'h83);
        chk("R2 rx reset empties", int'(rx_lvl), 0);
        chk("R2 tx untouched", int'(tx_lvl), 2);
        wr(8'h85);
        chk("R2 tx reset empties", int'(tx_lvl), 0);
        chk("R2 tx irq idle after reset", int'(tx_irq), 0);
        step(1, 0, 0, 0);
        chk("R2 strobe self-clears", int'(rx_lvl), 1);

        wr(8'hD5);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0);
        idle(2);
        chk("R6 armed no irq", int'(tx_irq), 0);
        step(0, 0, 0, 1); idle(2);
        chk("R6 equal to trig no irq", int'(tx_irq), 0);
        step(0, 0, 0, 1); idle(2);
        chk("R6 below trig irq", int'(tx_irq), 1);
        chk("R9 tx source stat", int'(stat_byte), exp_stat(1, 0, 1));
        rd();
        chk("R8 read clears tx", int'(tx_irq), 0);
        chk("R9 none pending stat", int'(stat_byte), exp_stat(1, 0, 0));

        wr(8'hD5);
        step(0, 0, 1, 0); step(0, 0, 1, 0);
        step(0, 0, 0, 1); idle(2);
        chk("R7 not empty no irq", int'(tx_irq), 0);
        step(0, 0, 0, 1); idle(2);
        chk("R7 empty raises irq", int'(tx_irq), 1);

        for (int i = 0; i < 5; i++) step(0, 0, 1, 0);
        idle(2);
        chk("R8 refill clears tx", int'(tx_irq), 0);
        step(0, 0, 0, 1); step(0, 0, 0, 1); idle(2);
        chk("R6 tx pending again", int'(tx_irq), 1);
        for (int i = 0; i < 13; i++) step(1, 0, 0, 0);
        chk("R9 rx outranks tx", int'(stat_byte), exp_stat(1, 1, 1));
        rd(); idle(1);
        chk("R8 read under rx keeps tx", int'(tx_irq), 1);
        step(0, 1, 0, 0);
        chk("R9 tx shown after rx drops", int'(stat_byte), exp_stat(1, 0, 1));

        wr(8'h09);
        chk("R10 dma stored", int'(dma_mode), 1);
        chk("R10 stat with dma", int'(stat_byte), exp_stat(1, 1, 0));
        wr(8'h01);
        chk("R10 dma cleared", int'(dma_mode), 0);
        chk("R10 stat without dma", int'(stat_byte), exp_stat(1, 1, 0));

        wr(8'h07);
        for (int r = 0; r < 4; r++) begin
            logic [1:0] rc;
            logic [1:0] tc;
            rc = 2'($urandom);
            tc = 2'($urandom);
            wr({rc, tc, 4'b0001});
            for (int i = 0; i < 200; i++) begin
                int rp;
                int ro;
                rp = (($urandom % 100) < 55) ? 1 : 0;
                ro = (($urandom % 100) < 45) ? 1 : 0;
                step(rp, ro, int'($urandom % 2), int'($urandom % 2));
                chk("R11 random rx_lvl", int'(rx_lvl), mrx);
                chk("R11 random tx_lvl", int'(tx_lvl), mtx);
                chk("R5 random rx_irq", int'(rx_irq), (mrx >= rx_t) ? 1 : 0);
            end
        end

        finish_run();
    end

endmodule